// File: doc/BRIEF.md
# DMA Source Address Counter

This block holds the source address of one DMA channel. Software can read and write the 32-bit register at any time. While a transfer runs, the register steps forward or backward by the beat size after each completed beat, so it always shows where the next beat will read from. When a transfer starts, and before every beat, the block checks that the current address sits on a boundary that suits the selected beat size. A misaligned address sets a sticky error flag that also halts the channel.

In single-address transfers where an external device that answers with an acknowledge strobe acts as the source, the address plays no part. The block then neither checks it nor steps it. A special handshake mode changes who may load the register. In that mode CPU writes are blocked unless a configuration bit allows them, and a 32-bit request word from the external device can load the register. When several writers act in the same cycle, the result follows a fixed priority.

Top module: `dma_src_addr_ctr`

## Requirements
- R1: A CPU write (`cpu_wr_en`) outside handshake mode loads all 32 bits of `cpu_wr_data`, and `src_addr` shows the new value one clock later.
- R2: On `beat_done`, `addr_mode` picks the step: 1 adds the beat size, 2 subtracts it, and 0 or 3 keeps the address. Arithmetic wraps modulo 2^32.
- R3: `xfer_size` codes 0, 1, 2 and 3 mean beats of 2, 4, 8 and 32 bytes. An address is aligned when its low 1, 2, 3 or 5 bits are zero.
- R4: A pulse on `xfer_start` or `beat_req` while the current `src_addr` is misaligned for `xfer_size` sets `addr_err` one clock later.
- R5: While `ext_src_ack` is high, no alignment check is made and `beat_done` leaves the address unchanged.
- R6: `halt` follows `addr_err`. While halted, or in a cycle whose check fails, `beat_done` does not step the address.
- R7: `addr_err` is 0 after reset and stays set until `err_clr`. If a failing check and `err_clr` come in the same cycle, the error stays set.
- R8: With `hs_mode` high, CPU writes are ignored unless `both_wr_ok` is high. `ext_ld_en` loads `ext_ld_word` only while `hs_mode` is high and has no effect otherwise.
- R9: Load priority, from highest: external word load, CPU write, beat step.
- R10: Pulling `rst_n` low clears `addr_err` and `halt` at once, without waiting for a clock edge. The internal reset is released two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_wr_data | input | 32 | CPU write value |
| hs_mode | input | 1 | Special handshake mode select |
| both_wr_ok | input | 1 | Allow CPU writes in handshake mode |
| ext_ld_en | input | 1 | External request word load strobe |
| ext_ld_word | input | 32 | External request word |
| ext_src_ack | input | 1 | Source is an acknowledge-handshake device; the address is unused |
| xfer_size | input | 2 | Beat size code |
| addr_mode | input | 2 | Step mode: 0 hold, 1 up, 2 down, 3 hold |
| xfer_start | input | 1 | Transfer start pulse; triggers an alignment check |
| beat_req | input | 1 | Pre-beat pulse; triggers an alignment check |
| beat_done | input | 1 | Completed beat; steps the address |
| err_clr | input | 1 | Software clear of the error flag |
| src_addr | output | 32 | Current source address |
| addr_err | output | 1 | Sticky alignment error |
| halt | output | 1 | Channel halt request |

## Verification
The bench builds the block with its default 32-bit address and a two-stage reset synchronizer. With these values the full wrap-around of the up and down steps can be reached by loading addresses close to 0 and close to 2^32. All four beat sizes are exercised at both the 2-byte and the 32-byte extremes. The two-edge reset release can be observed directly at the ports.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  typedef enum logic [1:0] {
    SZ_B2  = 2'd0,
    SZ_B4  = 2'd1,
    SZ_B8  = 2'd2,
    SZ_B32 = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_UP    = 2'd1,
    STEP_DOWN  = 2'd2,
    STEP_HOLD2 = 2'd3
  } step_mode_e;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_STEP = 2'd1,
    SRC_CPU  = 2'd2,
    SRC_EXT  = 2'd3
  } load_sel_e;

  localparam int NUM_SIZES = 4;
  localparam int LOW_W     = 5;

  function automatic int unsigned size_shift(input size_e s);
    case (s)
      SZ_B2:   return 1;
      SZ_B4:   return 2;
      SZ_B8:   return 3;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/dsa_align_chk.sv
module dsa_align_chk
  import dsa_pkg::*;
(
  input  logic [LOW_W-1:0] addr_low,
  input  logic [1:0]       size_code,
  output logic             misaligned
);

  logic [LOW_W-1:0] mask_tab [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_mask
    localparam int unsigned SH = size_shift(size_e'(g));
    assign mask_tab[g] = LOW_W'((32'd1 << SH) - 32'd1);
  end

  always_comb begin
    misaligned = |(addr_low & mask_tab[size_code]);
  end

endmodule

// File: rtl/dsa_step_calc.sv
module dsa_step_calc
  import dsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [1:0]        size_code,
  input  logic [1:0]        mode_code,
  output logic [ADDR_W-1:0] next_addr,
  output logic              moving
);

  logic [ADDR_W-1:0] step;
  step_mode_e        mode;

  always_comb begin
    mode = step_mode_e'(mode_code);
    step = ADDR_W'(1) << size_shift(size_e'(size_code));
    case (mode)
      STEP_UP: begin
        next_addr = cur_addr + step;
        moving    = 1'b1;
      end
      STEP_DOWN: begin
        next_addr = cur_addr - step;
        moving    = 1'b1;
      end
      default: begin
        next_addr = cur_addr;
        moving    = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dsa_wr_arb.sv
module dsa_wr_arb
  import dsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              cpu_wr_en,
  input  logic [ADDR_W-1:0] cpu_wr_data,
  input  logic              hs_mode,
  input  logic              both_wr_ok,
  input  logic              ext_ld_en,
  input  logic [ADDR_W-1:0] ext_ld_word,
  input  logic              step_ok,
  input  logic [ADDR_W-1:0] step_addr,
  output load_sel_e         sel,
  output logic [ADDR_W-1:0] load_val
);

  logic cpu_ok;
  logic ext_ok;

  always_comb begin
    cpu_ok = cpu_wr_en && (!hs_mode || both_wr_ok);
    ext_ok = ext_ld_en && hs_mode;
    if (ext_ok) begin
      sel      = SRC_EXT;
      load_val = ext_ld_word;
    end else if (cpu_ok) begin
      sel      = SRC_CPU;
      load_val = cpu_wr_data;
    end else if (step_ok) begin
      sel      = SRC_STEP;
      load_val = step_addr;
    end else begin
      sel      = SRC_KEEP;
      load_val = step_addr;
    end
  end

endmodule

// File: rtl/dma_src_addr_ctr.sv
module dma_src_addr_ctr
  import dsa_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [ADDR_W-1:0] cpu_wr_data,
  input  logic              hs_mode,
  input  logic              both_wr_ok,
  input  logic              ext_ld_en,
  input  logic [ADDR_W-1:0] ext_ld_word,
  input  logic              ext_src_ack,
  input  logic [1:0]        xfer_size,
  input  logic [1:0]        addr_mode,
  input  logic              xfer_start,
  input  logic              beat_req,
  input  logic              beat_done,
  input  logic              err_clr,
  output logic [ADDR_W-1:0] src_addr,
  output logic              addr_err,
  output logic              halt
);

  // reset: asserted at once, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;
  logic              err_q;
  logic              err_d;
  logic              err_en;

  logic              check_now;
  logic              misaligned;
  logic              check_fail;
  logic [ADDR_W-1:0] step_addr;
  logic              moving;
  logic              step_ok;
  load_sel_e         sel;
  logic [ADDR_W-1:0] load_val;

  dsa_align_chk u_align (
    .addr_low  (addr_q[LOW_W-1:0]),
    .size_code (xfer_size),
    .misaligned(misaligned)
  );

  dsa_step_calc #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr (addr_q),
    .size_code(xfer_size),
    .mode_code(addr_mode),
    .next_addr(step_addr),
    .moving   (moving)
  );

  dsa_wr_arb #(.ADDR_W(ADDR_W)) u_arb (
    .cpu_wr_en  (cpu_wr_en),
    .cpu_wr_data(cpu_wr_data),
    .hs_mode    (hs_mode),
    .both_wr_ok (both_wr_ok),
    .ext_ld_en  (ext_ld_en),
    .ext_ld_word(ext_ld_word),
    .step_ok    (step_ok),
    .step_addr  (step_addr),
    .sel        (sel),
    .load_val   (load_val)
  );

  // next-state logic
  always_comb begin
    check_now  = (xfer_start || beat_req) && !ext_src_ack;
    check_fail = check_now && misaligned;
    step_ok    = beat_done && !ext_src_ack && !err_q && !check_fail && moving;

    addr_en = (sel != SRC_KEEP);
    addr_d  = load_val;

    err_en = check_fail || err_clr;
    err_d  = check_fail;
  end

  // address register: no reset, value kept until loaded
  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign src_addr = addr_q;
  assign addr_err = err_q;
  assign halt     = err_q;

endmodule

// File: rtl/dsa_src_addr_chk.sv
module dsa_src_addr_chk
  import dsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_q,
  input logic              cpu_wr_en,
  input logic [ADDR_W-1:0] cpu_wr_data,
  input logic              hs_mode,
  input logic              both_wr_ok,
  input logic              ext_ld_en,
  input logic [ADDR_W-1:0] ext_ld_word,
  input logic              ext_src_ack,
  input logic [1:0]        xfer_size,
  input logic [1:0]        addr_mode,
  input logic              xfer_start,
  input logic              beat_req,
  input logic              beat_done,
  input logic              err_clr,
  input logic [ADDR_W-1:0] src_addr,
  input logic              addr_err,
  input logic              halt
);

  logic              chk_mis;
  logic [ADDR_W-1:0] chk_step;
  logic              no_loads;

  always_comb begin
    chk_step = ADDR_W'(1) << size_shift(size_e'(xfer_size));
    chk_mis  = (src_addr & (chk_step - ADDR_W'(1))) != '0;
    no_loads = !cpu_wr_en && !ext_ld_en;
  end

  // R1
  cpu_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cpu_wr_en && !hs_mode && !ext_ld_en |=> src_addr == $past(cpu_wr_data));

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_q)
    beat_done && addr_mode == 2'd1 && !addr_err && !xfer_start && !beat_req &&
    !ext_src_ack && no_loads |=> src_addr == $past(src_addr) + $past(chk_step));

  // R4
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (xfer_start || beat_req) && !ext_src_ack && chk_mis |=> addr_err);

  // R5
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ext_src_ack && no_loads |=> $stable(src_addr));

  // R5
  ack_nochk_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ext_src_ack && !addr_err |=> !addr_err);

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    halt && no_loads |=> $stable(src_addr));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q)
    addr_err && !err_clr |=> addr_err);

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
    err_clr && !xfer_start && !beat_req |=> !addr_err);

  // R8
  cpu_mask_chk: assert property (@(posedge clk) disable iff (!rst_q)
    hs_mode && !both_wr_ok && !ext_ld_en && !beat_done |=> $stable(src_addr));

  // R9
  ext_win_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ext_ld_en && hs_mode |=> src_addr == $past(ext_ld_word));

endmodule

bind dma_src_addr_ctr dsa_src_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_q      (rst_int_n),
  .cpu_wr_en  (cpu_wr_en),
  .cpu_wr_data(cpu_wr_data),
  .hs_mode    (hs_mode),
  .both_wr_ok (both_wr_ok),
  .ext_ld_en  (ext_ld_en),
  .ext_ld_word(ext_ld_word),
  .ext_src_ack(ext_src_ack),
  .xfer_size  (xfer_size),
  .addr_mode  (addr_mode),
  .xfer_start (xfer_start),
  .beat_req   (beat_req),
  .beat_done  (beat_done),
  .err_clr    (err_clr),
  .src_addr   (src_addr),
  .addr_err   (addr_err),
  .halt       (halt)
);

// File: tb/dma_src_addr_ctr_test.sv
`timescale 1ns/1ps
module dma_src_addr_ctr_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr_en, hs_mode, both_wr_ok, ext_ld_en, ext_src_ack;
  logic [31:0] cpu_wr_data, ext_ld_word;
  logic [1:0]  xfer_size, addr_mode;
  logic        xfer_start, beat_req, beat_done, err_clr;
  logic [31:0] src_addr;
  logic        addr_err, halt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] m_addr;
  logic        m_err;

  always #5 clk = ~clk;

  dma_src_addr_ctr uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .hs_mode(hs_mode), .both_wr_ok(both_wr_ok),
    .ext_ld_en(ext_ld_en), .ext_ld_word(ext_ld_word),
    .ext_src_ack(ext_src_ack), .xfer_size(xfer_size), .addr_mode(addr_mode),
    .xfer_start(xfer_start), .beat_req(beat_req), .beat_done(beat_done),
    .err_clr(err_clr), .src_addr(src_addr), .addr_err(addr_err), .halt(halt)
  );

  function automatic logic [31:0] beat_bytes(input logic [1:0] s);
    case (s)
      2'd0: return 32'd2;
      2'd1: return 32'd4;
      2'd2: return 32'd8;
      default: return 32'd32;
    endcase
  endfunction

  function automatic logic exp_fail(input logic [31:0] a);
    return (xfer_start || beat_req) && !ext_src_ack &&
           ((a & (beat_bytes(xfer_size) - 32'd1)) != 0);
  endfunction

  function automatic logic exp_err(input logic [31:0] a, input logic e);
    if (exp_fail(a)) return 1'b1;
    if (err_clr)     return 1'b0;
    return e;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic e);
    logic adv;
    if (ext_ld_en && hs_mode) return ext_ld_word;
    if (cpu_wr_en && (!hs_mode || both_wr_ok)) return cpu_wr_data;
    adv = beat_done && !ext_src_ack && !e && !exp_fail(a);
    if (adv && addr_mode == 2'd1) return a + beat_bytes(xfer_size);
    if (adv && addr_mode == 2'd2) return a - beat_bytes(xfer_size);
    return a;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_wr_en = 0; hs_mode = 0; both_wr_ok = 0; ext_ld_en = 0; ext_src_ack = 0;
    xfer_start = 0; beat_req = 0; beat_done = 0; err_clr = 0;
  endtask

  // apply current inputs for one edge, then compare at the falling edge
  task automatic cyc(input string tag);
    logic [31:0] na;
    logic        ne;
    na = exp_addr(m_addr, m_err);
    ne = exp_err(m_addr, m_err);
    @(posedge clk);
    @(negedge clk);
    m_addr = na;
    m_err  = ne;
    check(tag, src_addr, m_addr);
    check(tag, {31'd0, addr_err}, {31'd0, m_err});
    check(tag, {31'd0, halt}, {31'd0, m_err});
    idle();
  endtask

  task automatic cpu_load(input logic [31:0] v);
    cpu_wr_en = 1; cpu_wr_data = v;
    cyc("R1");
  endtask

  task automatic do_reset();
    rst_n = 0;
    #1;
    check("R10", {31'd0, addr_err}, 32'd0);
    check("R10", {31'd0, halt}, 32'd0);
    m_err = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'h1a2b3c4d);
    idle();
    cpu_wr_data = 0; ext_ld_word = 0; xfer_size = 0; addr_mode = 0;
    m_addr = 0; m_err = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R7", {31'd0, addr_err}, 32'd0);
    rst_n = 1;
    // R10: internal reset still held after one edge: a failing check is ignored
    @(posedge clk); #1;
    xfer_start = 1; xfer_size = 2'd3;
    @(negedge clk);
    @(posedge clk); #1;
    xfer_start = 0;
    @(negedge clk);
    check("R10", {31'd0, addr_err}, 32'd0);
    @(negedge clk);

    // R1 full-width write
    cpu_load(32'hDEAD_BEEF);
    cpu_load(32'h0000_0100);

    // R2/R3 increment with 4-byte beats
    xfer_size = 2'd1; addr_mode = 2'd1; xfer_start = 1; cyc("R4");
    beat_req = 1; beat_done = 1; cyc("R2");
    check("R2", src_addr, 32'h0000_0104);
    // R3 32-byte down
    cpu_load(32'h0000_1000);
    xfer_size = 2'd3; addr_mode = 2'd2; beat_req = 1; beat_done = 1; cyc("R3");
    check("R3", src_addr, 32'h0000_0FE0);
    // R2 wrap up with 8-byte beats
    cpu_load(32'hFFFF_FFF8);
    xfer_size = 2'd2; addr_mode = 2'd1; beat_done = 1; cyc("R2");
    check("R2", src_addr, 32'h0000_0000);
    // R2 fixed modes
    addr_mode = 2'd0; beat_done = 1; cyc("R2");
    addr_mode = 2'd3; beat_done = 1; cyc("R2");
    check("R2", src_addr, 32'h0000_0000);

    // R4 misaligned address sets error; R6 beat in same cycle does not step
    cpu_load(32'h0000_0102);
    xfer_size = 2'd1; addr_mode = 2'd1; beat_req = 1; beat_done = 1; cyc("R4");
    check("R4", {31'd0, addr_err}, 32'd1);
    check("R6", src_addr, 32'h0000_0102);
    // R6 halted: no stepping
    beat_done = 1; cyc("R6");
    check("R6", {31'd0, halt}, 32'd1);
    // R7 set beats clear in same cycle
    xfer_start = 1; err_clr = 1; cyc("R7");
    check("R7", {31'd0, addr_err}, 32'd1);
    err_clr = 1; cyc("R7");
    check("R7", {31'd0, addr_err}, 32'd0);
    // R3 2-byte beats accept 0x102
    xfer_size = 2'd0; xfer_start = 1; cyc("R3");
    check("R3", {31'd0, addr_err}, 32'd0);

    // R5 acknowledge source: no check, no step
    cpu_load(32'h0000_0011);
    ext_src_ack = 1; xfer_size = 2'd3; xfer_start = 1; beat_req = 1;
    beat_done = 1; addr_mode = 2'd1; cyc("R5");
    check("R5", {31'd0, addr_err}, 32'd0);
    check("R5", src_addr, 32'h0000_0011);

    // R8 handshake mode masks CPU, allows with config bit
    hs_mode = 1; cpu_wr_en = 1; cpu_wr_data = 32'h1234_5678; cyc("R8");
    check("R8", src_addr, 32'h0000_0011);
    hs_mode = 1; both_wr_ok = 1; cpu_wr_en = 1; cpu_wr_data = 32'h1234_5678; cyc("R8");
    check("R8", src_addr, 32'h1234_5678);
    ext_ld_en = 1; ext_ld_word = 32'hCAFE_0000; cyc("R8");
    check("R8", src_addr, 32'h1234_5678);
    hs_mode = 1; ext_ld_en = 1; ext_ld_word = 32'hCAFE_0000; cyc("R8");
    check("R8", src_addr, 32'hCAFE_0000);

    // R9 priority
    hs_mode = 1; both_wr_ok = 1; ext_ld_en = 1; ext_ld_word = 32'hA5A5_0040;
    cpu_wr_en = 1; cpu_wr_data = 32'h5A5A_0080; beat_done = 1; addr_mode = 2'd1; cyc("R9");
    check("R9", src_addr, 32'hA5A5_0040);
    cpu_wr_en = 1; cpu_wr_data = 32'h5A5A_0080; beat_done = 1; addr_mode = 2'd1;
    xfer_size = 2'd1; cyc("R9");
    check("R9", src_addr, 32'h5A5A_0080);

    // R10 asynchronous clear mid-cycle
    cpu_load(32'h0000_0003);
    xfer_size = 2'd1; xfer_start = 1; cyc("R4");
    check("R4", {31'd0, addr_err}, 32'd1);
    @(posedge clk); #2;
    do_reset();

    // random mix, R1 R2 R4 R6 R7 R8 R9
    cpu_load(32'h0000_2000);
    for (int i = 0; i < 4000; i++) begin
      cpu_wr_en   = ($urandom % 8) == 0;
      cpu_wr_data = $urandom & (($urandom % 3) == 0 ? 32'hFFFF_FFFF : 32'hFFFF_FFE0);
      ext_ld_en   = ($urandom % 10) == 0;
      ext_ld_word = $urandom & (($urandom % 3) == 0 ? 32'hFFFF_FFFF : 32'hFFFF_FFE0);
      hs_mode     = ($urandom % 4) == 0;
      both_wr_ok  = ($urandom % 2) == 0;
      ext_src_ack = ($urandom % 8) == 0;
      xfer_size   = 2'($urandom % 4);
      addr_mode   = 2'($urandom % 4);
      xfer_start  = ($urandom % 16) == 0;
      beat_req    = ($urandom % 3) == 0;
      beat_done   = ($urandom % 2) == 0;
      err_clr     = ($urandom % 6) == 0;
      cyc("R9");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule